// File: doc/BRIEF.md
# Serial DAC Command Front End

This block is the digital front end of a 12-bit voltage-output converter. A host writes 16-bit words over a three-wire serial link: an active-low select, a serial clock and a data line. The block runs on a faster system clock. It brings the three serial lines into that clock through synchronizers and finds the serial clock's falling edges and the select's edges there. It assembles each word most significant bit first and commits it only once all sixteen bits have arrived under one select.

A committed word is decoded into one of two things. It is either a new converter code or a power command. A power command wakes the converter or puts it into one of three powered-down output terminations. The block holds the code, the power state and the termination choice, and starts from a safe default after reset. After every wake-up it raises a busy flag for a recovery window. That window is set in system clock cycles from a clock-frequency parameter and a recovery time in microseconds.

Top module: `sdac_cmd_front`

## Requirements
- R1: After reset, code_o is 0, oe_o is 0, term_o is 2'b11 (100k to ground) and busy_o is 0.
- R2: A frame is 16 bits sampled on serial clock falling edges that follow a falling edge of cs_ni, first bit most significant. Bits [15:12] are the command and bits [11:0] the data field.
- R3: Command 4'b0000 copies the data field to code_o. It leaves oe_o and term_o unchanged, whether the converter is awake or powered down.
- R4: Command 4'b1111 selects a power state from data bits [1:0]; data bits [11:2] are don't-care. The encodings are: 00 wakes (oe_o=1, term_o=2'b00); 01 powers down floating (oe_o=0, term_o=2'b01); 10 powers down to 1k (oe_o=0, term_o=2'b10); 11 powers down to 100k (oe_o=0, term_o=2'b11).
- R5: code_o keeps its value through power-down and wake-up commands.
- R6: If cs_ni rises before the 16th falling edge of a frame, the partial frame is dropped and no output changes.
- R7: Serial clock edges after the 16th bit of a frame are ignored, and so are edges while cs_ni is high. Only a new falling edge of cs_ni starts another frame.
- R8: Command nibbles other than 4'b0000 and 4'b1111 change no output.
- R9: A wake command holds busy_o high for exactly (CLK_HZ/1000000)*WAKE_US system clock cycles, 400 at the defaults. A power-down command ends busy_o at once.
- R10: Frames are accepted with the serial clock idling either high or low between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Active-low serial select |
| sclk_i | input | 1 | Serial clock, data sampled on its falling edge |
| din_i | input | 1 | Serial data |
| code_o | output | 12 | Held converter code |
| oe_o | output | 1 | Converter awake, output driven |
| term_o | output | 2 | Termination: 00 driven, 01 floating, 10 1k, 11 100k |
| busy_o | output | 1 | Wake-up recovery window active |

## Verification
The hardest situations to reach are select edges at the frame boundary. One is a select rise after only a few, or exactly fifteen, clock edges. The other is a select held low while more clocks follow the sixteenth bit. The bench reaches both with a bit-level task that drives any number of clock edges from a 32-bit pattern and then chooses whether to raise the select. A power-down that lands inside the wake-up window is forced by sending it right after a wake command. A passive monitor measures the busy pulse length.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  typedef enum logic [1:0] {
    TERM_DRIVEN = 2'b00,
    TERM_FLOAT  = 2'b01,
    TERM_1K     = 2'b10,
    TERM_100K   = 2'b11
  } term_e;

  localparam logic [3:0] CMD_LOAD = 4'h0;
  localparam logic [3:0] CMD_PWR  = 4'hF;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/sdac_frame.sv
module sdac_frame #(
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n_s,
  input  logic               sclk_s,
  input  logic               din_s,
  output logic               frame_vld_o,
  output logic [FRAME_W-1:0] frame_o
);
  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_W - 1);

  logic               cs_d_q, sclk_d_q;
  logic               active_q, active_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [FRAME_W-2:0] sh_q, sh_d;
  logic               vld_q, vld_d;
  logic [FRAME_W-1:0] word_q, word_d;
  logic               word_en;
  logic               cs_fall, sclk_fall;

  assign cs_fall   = cs_d_q & ~cs_n_s;
  assign sclk_fall = sclk_d_q & ~sclk_s;

  always_comb begin
    active_d = active_q;
    cnt_d    = cnt_q;
    sh_d     = sh_q;
    vld_d    = 1'b0;
    word_en  = 1'b0;
    word_d   = {sh_q, din_s};
    if (cs_n_s) begin
      active_d = 1'b0;
      cnt_d    = '0;
    end else if (cs_fall) begin
      active_d = 1'b1;
      cnt_d    = '0;
    end else if (active_q && sclk_fall && (cnt_q < CNT_FULL)) begin
      sh_d  = {sh_q[FRAME_W-3:0], din_s};
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == CNT_LAST) begin
        vld_d   = 1'b1;
        word_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_d_q   <= 1'b1;
      sclk_d_q <= 1'b0;
      active_q <= 1'b0;
      cnt_q    <= '0;
      sh_q     <= '0;
      vld_q    <= 1'b0;
    end else begin
      cs_d_q   <= cs_n_s;
      sclk_d_q <= sclk_s;
      active_q <= active_d;
      cnt_q    <= cnt_d;
      sh_q     <= sh_d;
      vld_q    <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (word_en) begin
      word_q <= word_d;
    end
  end

  assign frame_vld_o = vld_q;
  assign frame_o     = word_q;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_FULL); // R7
  AST_FRAME_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> (cnt_q == CNT_FULL)); // R2
  AST_DESELECT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |=> (!vld_q && cnt_q == '0)); // R6
endmodule

// File: rtl/sdac_ctrl.sv
module sdac_ctrl
  import sdac_pkg::*;
#(
  parameter int CODE_W   = 12,
  parameter int CMD_W    = 4,
  parameter int WAKE_CYC = 400
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    frame_vld_i,
  input  logic [CMD_W+CODE_W-1:0] frame_i,
  output logic [CODE_W-1:0]       code_o,
  output logic                    oe_o,
  output term_e                   term_o,
  output logic                    busy_o
);
  localparam int BW = $clog2(WAKE_CYC + 1);
  localparam logic [BW-1:0] BUSY_LOAD = BW'(WAKE_CYC);

  logic [CMD_W-1:0]  cmd;
  logic [CODE_W-1:0] data;
  logic [1:0]        pwr_sel;
  logic              wake_cmd;

  logic [CODE_W-1:0] code_q, code_d;
  logic              code_en;
  logic              awake_q, awake_d;
  term_e             term_q, term_d;
  logic [BW-1:0]     bcnt_q, bcnt_d;

  assign cmd      = frame_i[CMD_W+CODE_W-1:CODE_W];
  assign data     = frame_i[CODE_W-1:0];
  assign pwr_sel  = data[1:0];
  assign wake_cmd = frame_vld_i && (cmd == CMD_PWR) && (pwr_sel == 2'b00);

  always_comb begin
    code_d  = data;
    code_en = 1'b0;
    awake_d = awake_q;
    term_d  = term_q;
    bcnt_d  = (bcnt_q != '0) ? bcnt_q - 1'b1 : '0;
    if (frame_vld_i) begin
      if (cmd == CMD_LOAD) begin
        code_en = 1'b1;
      end else if (cmd == CMD_PWR) begin
        term_d  = term_e'(pwr_sel);
        awake_d = (pwr_sel == 2'b00);
        bcnt_d  = (pwr_sel == 2'b00) ? BUSY_LOAD : '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      awake_q <= 1'b0;
      term_q  <= TERM_100K;
      bcnt_q  <= '0;
    end else begin
      awake_q <= awake_d;
      term_q  <= term_d;
      bcnt_q  <= bcnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
    end else if (code_en) begin
      code_q <= code_d;
    end
  end

  assign code_o = code_q;
  assign oe_o   = awake_q;
  assign term_o = term_q;
  assign busy_o = (bcnt_q != '0);

  AST_OE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    oe_o |-> (term_o == TERM_DRIVEN)); // R4
  AST_OFF_TERMINATED: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_o |-> (term_o != TERM_DRIVEN)); // R4
  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_vld_i |=> $stable(code_o)); // R5
  AST_WAKE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    wake_cmd |=> busy_o); // R9
  AST_BUSY_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> oe_o); // R9
  AST_BAD_CMD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_vld_i && cmd != CMD_LOAD && cmd != CMD_PWR)
      |=> $stable({code_o, oe_o, term_o})); // R8
endmodule

// File: rtl/sdac_cmd_front.sv
module sdac_cmd_front
  import sdac_pkg::*;
#(
  parameter int CLK_HZ  = 50_000_000,
  parameter int WAKE_US = 8,
  parameter int CODE_W  = 12,
  parameter int CMD_W   = 4
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              din_i,
  output logic [CODE_W-1:0] code_o,
  output logic              oe_o,
  output logic [1:0]        term_o,
  output logic              busy_o
);
  localparam int FRAME_W  = CMD_W + CODE_W;
  localparam int WAKE_CYC = (CLK_HZ / 1_000_000) * WAKE_US;

  logic [1:0]         rst_pipe_q;
  logic               rst_n;
  logic [2:0]         pins_s;
  logic               frame_vld;
  logic [FRAME_W-1:0] frame;
  term_e              term;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_n = rst_pipe_q[1];

  sdac_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({cs_ni, sclk_i, din_i}),
    .q_o   (pins_s)
  );

  sdac_frame #(.FRAME_W(FRAME_W)) u_frame (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n_s      (pins_s[2]),
    .sclk_s      (pins_s[1]),
    .din_s       (pins_s[0]),
    .frame_vld_o (frame_vld),
    .frame_o     (frame)
  );

  sdac_ctrl #(.CODE_W(CODE_W), .CMD_W(CMD_W), .WAKE_CYC(WAKE_CYC)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_vld_i (frame_vld),
    .frame_i     (frame),
    .code_o      (code_o),
    .oe_o        (oe_o),
    .term_o      (term),
    .busy_o      (busy_o)
  );

  assign term_o = term;
endmodule

// File: tb/tb_sdac_cmd_front.sv
`timescale 1ns/1ps
module tb_sdac_cmd_front;
  localparam int CLK_HZ   = 50_000_000;
  localparam int WAKE_US  = 8;
  localparam int WAKE_CYC = (CLK_HZ / 1_000_000) * WAKE_US;
  localparam int H        = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cs_ni = 1'b1;
  logic        sclk_i = 1'b0;
  logic        din_i = 1'b0;
  logic [11:0] code_o;
  logic        oe_o;
  logic [1:0]  term_o;
  logic        busy_o;

  int checks = 0;
  int failures = 0;
  int busy_run = 0;
  int last_busy_len = 0;
  bit done = 1'b0;

  logic [11:0] exp_code;
  logic        exp_oe;
  logic [1:0]  exp_term;

  always #10 clk = ~clk;

  sdac_cmd_front #(.CLK_HZ(CLK_HZ), .WAKE_US(WAKE_US)) dut (
    .clk(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .sclk_i(sclk_i),
    .din_i(din_i), .code_o(code_o), .oe_o(oe_o), .term_o(term_o),
    .busy_o(busy_o)
  );

  always @(negedge clk) begin
    if (busy_o) busy_run = busy_run + 1;
    else if (busy_run != 0) begin
      last_busy_len = busy_run;
      busy_run = 0;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Drives n clock edges taken MSB-first from v, then optionally raises select.
  task automatic send_bits(input logic [31:0] v, input int n, input bit idle_hi,
                           input bit raise_cs);
    sclk_i = idle_hi;
    wait_n(H);
    cs_ni = 1'b0;
    wait_n(H);
    for (int i = 0; i < n; i++) begin
      sclk_i = 1'b1;
      din_i  = v[31-i];
      wait_n(H);
      sclk_i = 1'b0;
      wait_n(H);
    end
    sclk_i = idle_hi;
    wait_n(H);
    if (raise_cs) cs_ni = 1'b1;
    wait_n(8);
  endtask

  task automatic send_word(input logic [15:0] w, input bit idle_hi);
    send_bits({w, 16'h0000}, 16, idle_hi, 1'b1);
  endtask

  task automatic chk_state(input string req);
    chk({req, " code"}, int'(code_o), int'(exp_code));
    chk({req, " oe"}, int'(oe_o), int'(exp_oe));
    chk({req, " term"}, int'(term_o), int'(exp_term));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    wait_n(5);
    rst_ni = 1'b1;
    wait_n(5);

    // R1: reset state
    exp_code = 12'h000; exp_oe = 1'b0; exp_term = 2'b11;
    chk_state("R1 reset");
    chk("R1 busy", int'(busy_o), 0);

    // R2 R3 R10: code sweep while powered down, alternating idle level
    for (int i = 0; i < 64; i++) begin
      logic [11:0] c;
      c = (i == 63) ? 12'hFFF : 12'((i * 65 + 3) % 4096);
      send_word({4'h0, c}, bit'(i[0]));
      exp_code = c;
      chk_state("R3 load while down R10");
    end

    // R4 R5 R9: wake keeps the code and starts a busy window
    last_busy_len = 0;
    send_word(16'hF000, 1'b0);
    exp_oe = 1'b1; exp_term = 2'b00;
    chk_state("R4 wake R5");
    chk("R9 busy after wake", int'(busy_o), 1);
    wait_n(WAKE_CYC + 50);
    chk("R9 busy length", last_busy_len, WAKE_CYC);

    // R2 R3: loads while awake
    send_word(16'h0A5C, 1'b1);
    exp_code = 12'hA5C;
    chk_state("R2 R3 load awake");

    // R4 R5: each power-down mode with junk in the upper data bits, then wake
    for (int k = 1; k < 4; k++) begin
      send_word({4'hF, 12'hB68 | 12'(k)}, bit'(k[0]));
      exp_oe = 1'b0; exp_term = 2'(k);
      chk_state("R4 power-down mode R5");
      send_word({4'hF, 12'h7F4}, 1'b0);
      exp_oe = 1'b1; exp_term = 2'b00;
      chk_state("R5 wake restores");
    end

    // R8: other command nibbles change nothing
    for (int n = 1; n < 15; n++) begin
      send_word({4'(n), 12'h3C1 ^ 12'(n)}, bit'(n[0]));
      chk_state("R8 ignored nibble");
    end

    // R6: partial frames dropped
    send_bits({16'h0123, 16'h0}, 1, 1'b0, 1'b1);
    chk_state("R6 partial 1");
    send_bits({16'h0123, 16'h0}, 8, 1'b1, 1'b1);
    chk_state("R6 partial 8");
    send_bits({16'h0123, 16'h0}, 15, 1'b0, 1'b1);
    chk_state("R6 partial 15");
    send_bits({16'hF003, 16'h0}, 15, 1'b1, 1'b1);
    chk_state("R6 partial power 15");

    // R7: extra clocks after the 16th bit are ignored
    send_bits({16'h0ABC, 16'h0FFF}, 32, 1'b0, 1'b1);
    exp_code = 12'hABC;
    chk_state("R7 extra clocks");
    send_bits({16'h0DEF, 16'hF003}, 32, 1'b1, 1'b0);
    exp_code = 12'hDEF;
    chk_state("R7 select held low");
    cs_ni = 1'b1;
    wait_n(8);
    // R7: clocks with select high do nothing
    for (int i = 0; i < 16; i++) begin
      sclk_i = 1'b1; din_i = 1'b1; wait_n(H);
      sclk_i = 1'b0; wait_n(H);
    end
    wait_n(8);
    chk_state("R7 clocks deselected");

    // R9: power-down inside the wake window ends busy early
    wait_n(WAKE_CYC + 20);
    last_busy_len = 0;
    send_word(16'hF000, 1'b0);
    send_word(16'hF003, 1'b0);
    exp_oe = 1'b0; exp_term = 2'b11;
    chk_state("R9 down during busy");
    chk("R9 busy cleared", int'(busy_o), 0);
    chk("R9 busy cut short", int'(last_busy_len > 0 && last_busy_len < WAKE_CYC), 1);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule